// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from peripheral sources into a pending-status register. It gates them with a mask register and drives a single interrupt line toward the CPU. Each source raises a one-cycle request pulse, and that pulse sets its status bit. The bit stays set until software acknowledges it. Acknowledging is done by writing the status register: every bit written as 0 is cleared, and every bit written as 1 is left as it was. The mask register is plain read/write storage. The interrupt line is high whenever some pending bit is also enabled in the mask.

Both registers sit on a simple register bus made of:
- an address;
- write and read strobes;
- an access-size select for 16-bit or 32-bit accesses;
- write data and read data.

A 16-bit access covers only the low half of a register. The DMA controller's interrupt logic has its own request input, and it lands on status bit 3. Writing the mask re-evaluates the interrupt line at once. A bit that is already pending therefore raises the line one cycle after it is unmasked, with no new request needed.

Top module: `irq_stat_mask_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both registers become zero and `irq_out` is 0 from the following edge on.
- R2: A 1 on `src_req[i]` at a clock edge sets status bit i. A 1 on `dma_req` sets status bit 3. Set bits stay set until acknowledged.
- R3: A write to offset 0x070 replaces the status register with its current value ANDed with the write data. A written 0 clears the bit and a written 1 keeps it.
- R4: A 32-bit write to offset 0x074 replaces the whole mask register with the write data.
- R5: A write with `bus_wide`=0 (16-bit access) changes only bits 15:0 of the addressed register. For a status write, bits above 15 are kept. For a mask write, bits above 15 keep their old value. `bus_wide`=1 selects a 32-bit access.
- R6: A read strobe at an edge places the value the register held before that edge on `bus_rdata` from that edge on. Offset 0x070 returns status and offset 0x074 returns mask. A 16-bit read returns zeros in bits 31:16. Bits at or above NSRC read as 0. Any other offset reads 0, and so does a cycle without a read strobe.
- R7: `irq_out` is a register that holds the OR over all bits of (status AND mask) as they stood before the previous edge. A mask write that uncovers a pending bit raises `irq_out` one cycle later, without a new request.
- R8: When a request and a status write that clears the same bit fall in the same cycle, the bit ends up set.
- R9: A write to any offset other than 0x070 or 0x074 leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset within the I/O window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access (low half) |
| bus_wdata | input | DATA_W | Write data |
| src_req | input | NSRC | Per-source request pulses |
| dma_req | input | 1 | DMA interrupt request pulse, sets status bit 3 |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Registered CPU interrupt line |

## Verification
The bound checker watches several properties on every cycle:
- every request lands, including when a clearing write hits the same bit in the same cycle;
- no status bit rises without a request;
- the mask holds its value when it is not written;
- a 16-bit mask write leaves the upper half alone;
- `irq_out` follows the previous cycle's masked pending set.

Some behaviour only the bench scenarios can show:
- the exact AND result of acknowledge writes under many data patterns;
- read-back values and the low-half truncation of 16-bit reads;
- the effect of writes to foreign offsets;
- the single-cycle delay between unmasking an already-pending bit and the rise of the interrupt line.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_STAT = 2'd1,
    TGT_MASK = 2'd2
  } irq_tgt_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              wide,
  output irq_tgt_e          tgt,
  output logic              stat_wr,
  output logic              mask_wr,
  output logic [DATA_W-1:0] lane
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (addr == STAT_OFS)      tgt = TGT_STAT;
    else if (addr == MASK_OFS) tgt = TGT_MASK;
    else                       tgt = TGT_NONE;
  end

  assign stat_wr = wr && (tgt == TGT_STAT);
  assign mask_wr = wr && (tgt == TGT_MASK);
  // 16-bit accesses cover the low half only
  assign lane = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic            ack_en,
  input  logic [NSRC-1:0] ack_keep,
  output logic [NSRC-1:0] status
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)
        bit_q <= 1'b0;
      else if (set_vec[i])
        bit_q <= 1'b1;              // set has priority over acknowledge
      else if (ack_en && !ack_keep[i])
        bit_q <= 1'b0;
    end
    assign status[i] = bit_q;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [NSRC-1:0] lane,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] mask
);
  logic [NSRC-1:0] mask_q;
  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (we)
      mask_q <= (mask_q & ~lane) | (wdata & lane);
  end
  assign mask = mask_q;
endmodule

// File: rtl/irq_stat_mask_ctrl.sv
module irq_stat_mask_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NSRC    = 24,
  parameter int DMA_BIT = 3,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h070,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h074
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_wide,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [NSRC-1:0]   src_req,
  input  logic              dma_req,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  irq_tgt_e          tgt;
  logic              stat_wr;
  logic              mask_wr;
  logic [DATA_W-1:0] lane;
  logic [NSRC-1:0]   set_vec;
  logic [NSRC-1:0]   status_q;
  logic [NSRC-1:0]   mask_q;
  logic [NSRC-1:0]   ack_keep;
  logic [DATA_W-1:0] rd_sel;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_q;

  irq_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .wide(bus_wide),
    .tgt(tgt), .stat_wr(stat_wr), .mask_wr(mask_wr), .lane(lane)
  );

  always_comb begin
    set_vec = src_req;
    set_vec[DMA_BIT] = src_req[DMA_BIT] | dma_req;
  end

  // bits outside the access lane are kept
  assign ack_keep = bus_wdata[NSRC-1:0] | ~lane[NSRC-1:0];

  irq_status_bank #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .ack_en(stat_wr), .ack_keep(ack_keep), .status(status_q)
  );

  irq_mask_bank #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .we(mask_wr), .lane(lane[NSRC-1:0]),
    .wdata(bus_wdata[NSRC-1:0]), .mask(mask_q)
  );

  always_comb begin
    unique case (tgt)
      TGT_STAT: rd_sel = DATA_W'(status_q);
      TGT_MASK: rd_sel = DATA_W'(mask_q);
      default:  rd_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd ? (rd_sel & lane) : '0;
      irq_q   <= |(status_q & mask_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
  parameter int NSRC    = 24,
  parameter int DATA_W  = 32,
  parameter int DMA_BIT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_req,
  input logic              dma_req,
  input logic              mask_wr,
  input logic              bus_wide,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NSRC-1:0]   status,
  input logic [NSRC-1:0]   mask,
  input logic              irq_out
);
  logic            armed_a, armed_b;
  logic [NSRC-1:0] req_all;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_a <= 1'b0;
      armed_b <= 1'b0;
    end else begin
      armed_a <= 1'b1;
      armed_b <= armed_a;
    end
  end

  assign req_all = src_req | (NSRC'(dma_req) << DMA_BIT);

  AST_RESET_IRQ_LOW: assert property (@(posedge clk) rst |=> !irq_out); // R1
  AST_REQ_LANDS: assert property (@(posedge clk) disable iff (rst || !armed_b)
    (|req_all) |=> ((status & $past(req_all)) == $past(req_all))); // R8
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst || !armed_b)
    1'b1 |=> ((status & ~$past(status) & ~$past(req_all)) == '0)); // R2
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst || !armed_b)
    !mask_wr |=> $stable(mask)); // R9
  AST_MASK_FULL_WRITE: assert property (@(posedge clk) disable iff (rst || !armed_b)
    (mask_wr && bus_wide) |=> (mask == $past(bus_wdata[NSRC-1:0]))); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst || !armed_b)
    1'b1 |=> (irq_out == |($past(status & mask)))); // R7

  if (NSRC > 16) begin : g_upper
    AST_NARROW_MASK_UPPER: assert property (@(posedge clk) disable iff (rst || !armed_b)
      (mask_wr && !bus_wide) |=> $stable(mask[NSRC-1:16])); // R5
  end
endmodule

bind irq_stat_mask_ctrl irq_ctrl_checker #(
  .NSRC(NSRC), .DATA_W(DATA_W), .DMA_BIT(DMA_BIT)
) u_chk (
  .clk(clk), .rst(rst), .src_req(src_req), .dma_req(dma_req),
  .mask_wr(mask_wr), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
  .status(status_q), .mask(mask_q), .irq_out(irq_out)
);

// File: tb/irq_stat_mask_ctrl_test.sv
module irq_stat_mask_ctrl_test;
  localparam int NSRC = 24;
  localparam logic [31:0] NMASK = 32'((64'd1 << NSRC) - 1);
  localparam logic [11:0] A_STAT = 12'h070;
  localparam logic [11:0] A_MASK = 12'h074;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0, dma_req = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [NSRC-1:0] src_req = '0;
  logic [31:0] bus_rdata;
  logic irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] ms = '0;
  logic [31:0] mm = '0;
  logic [31:0] lf = 32'h1234_5678;

  always #2 clk = ~clk;

  irq_stat_mask_ctrl #(.NSRC(NSRC)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .src_req(src_req), .dma_req(dma_req),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // one bus cycle; the model is updated for the edge, outputs sampled 1 ns after it
  task automatic step(input logic wr, input logic rd, input logic [11:0] a, input logic wide,
                      input logic [31:0] d, input logic [31:0] req, input logic dma);
    logic [31:0] keep, set;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wide = wide; bus_wdata = d;
    src_req = req[NSRC-1:0]; dma_req = dma;
    @(posedge clk);
    set = (req | (32'(dma) << 3)) & NMASK;
    keep = wide ? d : (d | 32'hFFFF_0000);
    if (wr && a == A_STAT) ms = ms & keep;
    ms = (ms | set) & NMASK;
    if (wr && a == A_MASK) mm = (wide ? d : {mm[31:16], d[15:0]}) & NMASK;
    #1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0; src_req = '0; dma_req = 1'b0;
  endtask

  task automatic check_read(input logic [11:0] a, input logic wide, input string tag);
    logic [31:0] exp;
    exp = (a == A_STAT) ? ms : (a == A_MASK) ? mm : 32'h0;
    if (!wide) exp = exp & 32'h0000_FFFF;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_wide = wide;
    @(posedge clk); #1;
    chk(bus_rdata, exp, tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check_irq(input string tag);
    logic exp;
    exp = |(ms & mm);
    @(posedge clk); #1;
    chk(32'(irq_out), 32'(exp), tag);
  endtask

  task automatic next_lf();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(32'(irq_out), 32'h0, "R1 irq after reset");
    chk(bus_rdata, 32'h0, "R1 rdata after reset");
    @(negedge clk); rst = 1'b0;
    check_read(A_STAT, 1'b1, "R1 status after reset");
    check_read(A_MASK, 1'b1, "R1 mask after reset");

    // sweep each request bit with mask clear
    for (int i = 0; i < NSRC; i++) begin
      step(1'b0, 1'b0, 12'h0, 1'b1, 32'h0, 32'h1 << i, 1'b0);
      check_read(A_STAT, 1'b1, "R2 request sets bit");
      check_irq("R7 masked pending keeps irq low");
    end

    // unmask pending bits: irq must rise one cycle after the write, no new request
    step(1'b1, 1'b0, A_MASK, 1'b1, 32'hFFA5_5A5A, 32'h0, 1'b0);
    chk(32'(irq_out), 32'h0, "R7 irq not yet high at mask write edge");
    check_irq("R7 unmask of pending raises irq");
    check_read(A_MASK, 1'b1, "R4 mask full write");

    // acknowledge each bit, alternating access size
    for (int i = 0; i < NSRC; i++) begin
      step(1'b1, 1'b0, A_STAT, i[0], ~(32'h1 << i), 32'h0, 1'b0);
      check_read(A_STAT, 1'b1, (!i[0] && i >= 16) ? "R5 narrow ack keeps upper" : "R3 ack clears bit");
      check_irq("R7 irq after ack");
    end

    // set and clear of the same bit in one cycle
    step(1'b1, 1'b0, A_STAT, 1'b1, 32'h0, 32'h0000_0020, 1'b0);
    check_read(A_STAT, 1'b1, "R8 set beats clear");
    step(1'b1, 1'b0, A_STAT, 1'b1, 32'h0, 32'h0, 1'b1);
    check_read(A_STAT, 1'b1, "R8 dma set beats clear");
    check_read(A_STAT, 1'b0, "R2 dma request sets bit 3");

    // narrow mask write keeps upper half
    step(1'b1, 1'b0, A_MASK, 1'b0, 32'h0000_1234, 32'h0, 1'b0);
    check_read(A_MASK, 1'b1, "R5 narrow mask write");
    check_read(A_MASK, 1'b0, "R6 narrow read low half");
    check_read(12'h078, 1'b1, "R6 foreign offset reads zero");

    // pseudo-random mix of operations
    for (int n = 0; n < 120; n++) begin
      logic [11:0] a;
      string tag;
      next_lf();
      case (lf[2:0])
        3'd0, 3'd1: begin a = A_STAT; tag = "R3 random ack"; end
        3'd2, 3'd3: begin a = A_MASK; tag = "R4 random mask write"; end
        3'd4:       begin a = 12'h060; tag = "R9 foreign write ignored"; end
        3'd5:       begin a = 12'h072; tag = "R9 odd offset write ignored"; end
        default:    begin a = A_STAT; tag = "R5 random access"; end
      endcase
      step(1'b1, 1'b0, a, lf[3], {lf[15:0], lf[31:16]} ^ lf,
           lf[4] ? ((32'h1 << lf[9:5]) & NMASK) : 32'h0, lf[10]);
      check_read(A_STAT, lf[11], tag);
      check_read(A_MASK, 1'b1, tag);
      check_irq("R7 irq random");
    end

    // clear everything, then unmask with nothing pending
    step(1'b1, 1'b0, A_STAT, 1'b1, 32'h0, 32'h0, 1'b0);
    step(1'b1, 1'b0, A_MASK, 1'b1, 32'hFFFF_FFFF, 32'h0, 1'b0);
    check_irq("R7 no pending no irq");
    check_read(A_MASK, 1'b1, "R6 unimplemented mask bits read zero");

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    ms = '0; mm = '0;
    chk(32'(irq_out), 32'h0, "R1 irq after second reset");
    @(negedge clk); rst = 1'b0;
    check_read(A_MASK, 1'b1, "R1 mask cleared by reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule